// File: doc/BRIEF.md
# Loop Phase Detector Back End

This block is the digital back end of one frequency synthesizer loop. A programmable feedback divider counts VCO ticks and makes one divided strobe every N ticks. A phase-frequency detector compares that strobe with a reference strobe that arrives already selected. It produces a three-state error drive, modelled as a pair of enables. When `err_up` alone is high, the pin drives high. When `err_dn` alone is high, the pin drives low. When both are low, the pin floats. An out-of-lock flag is high while either enable is active.

All inputs belong to one fast clock domain. `vco_tick` and `ref_strobe` are one-cycle pulses that are valid on a clock edge. A power-down input freezes the divider and the detector. A status pin shows either the power-down state or, when the test select is set, the divided waveform.

Top module: `loop_phase_backend`

## Requirements
- R1: The divider counts clock edges on which `vco_tick` is high. It starts from position 0 after reset or power-down. On the edge that takes the N-th tick it wraps to position 0 and registers a divided strobe. N is `div_ratio`, valid from 16 to 65535.
- R2: A `div_ratio` below 16 (including 0) divides by 16.
- R3: With `test_sel` = 1, `status` is 1 while the divider position is at least floor(N/2) and 0 otherwise. This gives a square-ish wave at the VCO tick rate divided by N.
- R4: With `test_sel` = 0, `status` equals `pwr_down`.
- R5: The divided edge can lead, meaning it reaches the detector with no pending reference. In that case `err_dn` goes high one edge after the divided strobe is registered. It stays high until the edge that takes the next `ref_strobe`.
- R6: A `ref_strobe` taken with no pending divided edge sets `err_up` after that edge. It stays high until the edge on which the divided strobe reaches the detector.
- R7: A reference strobe and a divided strobe can reach the detector on the same edge with nothing pending. In that case neither enable and not `unlocked` rises, so the pin stays high-impedance.
- R8: `err_up` and `err_dn` are never high together. Both low means high-impedance.
- R9: `unlocked` is 1 exactly when `err_up` or `err_dn` is 1.
- R10: While `pwr_down` is 1, the divider is held at position 0, both enables are low and `unlocked` is low. After release, the first divided strobe needs a full N ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_tick | input | 1 | One pulse per VCO cycle |
| ref_strobe | input | 1 | One pulse per selected reference period |
| div_ratio | input | 16 | Feedback divide ratio N |
| pwr_down | input | 1 | Stops divider and detector |
| test_sel | input | 1 | Status pin shows divided waveform |
| err_up | output | 1 | Error pin driven high |
| err_dn | output | 1 | Error pin driven low |
| unlocked | output | 1 | Out-of-lock flag |
| status | output | 1 | Power-down state or divided waveform |

## Verification
The assertions take strobes to be single-cycle pulses that are sampled on the clock edge. They also take `pwr_down` to override every strobe on the same edge. A reference arriving on the same edge as a pending divided edge is taken as clearing the pending state. The stimulus drives both strobes only in the half period after an edge. It places each reference at a fixed offset from the divided edge (leading, lagging or coincident). It toggles power-down only after the detector has been allowed to reach a known state.

// File: rtl/lpb_pkg.sv
// Shared types for the loop phase detector back end.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package lpb_pkg;
    // Three-state error drive as seen at the pin.
    typedef enum logic [1:0] {
        PUMP_Z  = 2'b00,
        PUMP_UP = 2'b01,
        PUMP_DN = 2'b10
    } pump_e;
endpackage

// File: rtl/lpb_fb_divider.sv
// Feedback divider: counts VCO ticks, wraps on the N-th, emits a registered
// one-cycle strobe at the wrap and a half-period waveform for test viewing.
// Assumes: vco_tick is a one-cycle-per-VCO-period pulse in the clk domain.
module lpb_fb_divider #(
    parameter int W       = 16,
    parameter int MIN_DIV = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         fv_strobe,
    output logic         div_wave
);
    localparam logic [W-1:0] MinRatio = W'(MIN_DIV);

    logic [W-1:0] cnt_q;
    logic [W-1:0] eff_ratio;
    logic         wrap;

    // Clamp the ratio to the smallest legal value.
    always_comb eff_ratio = (ratio < MinRatio) ? MinRatio : ratio;

    // The terminal position is reached, or passed after a ratio decrease.
    always_comb wrap = tick && (cnt_q >= eff_ratio - 1'b1);

    // Position counter and divided strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q     <= '0;
            fv_strobe <= 1'b0;
        end else if (tick) begin
            cnt_q     <= wrap ? '0 : cnt_q + 1'b1;
            fv_strobe <= wrap;
        end else begin
            fv_strobe <= 1'b0;
        end
    end

    // Upper half of the count gives the divided waveform.
    always_comb div_wave = (cnt_q >= (eff_ratio >> 1));

    // R1
    strobe_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fv_strobe |-> (cnt_q == '0) && $past(tick));

    // R10
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q == '0) && !fv_strobe);
endmodule

// File: rtl/lpb_pfd.sv
// Phase-frequency detector: two flags set by reference and divided edges,
// both cleared on the edge that would set both. Drives a three-state pump.
// Assumes: strobes are single-cycle; hold clears and freezes both flags.
module lpb_pfd
    import lpb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hold,
    input  logic  fr,
    input  logic  fv,
    output pump_e pump
);
    logic up_q, dn_q;
    logic up_set, dn_set, both;

    // Candidate flag states before the mutual clear.
    always_comb begin
        up_set = up_q | fr;
        dn_set = dn_q | fv;
        both   = up_set & dn_set;
    end

    // Flag registers with zero-delay clear on coincidence.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_set & ~both;
            dn_q <= dn_set & ~both;
        end
    end

    // Pump state decode from the flags.
    always_comb begin
        unique case ({dn_q, up_q})
            2'b01:   pump = PUMP_UP;
            2'b10:   pump = PUMP_DN;
            default: pump = PUMP_Z;
        endcase
    end

    // R5
    lead_pulls_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fv && !fr && !hold && !up_q) |=> (pump == PUMP_DN));

    // R6
    lag_pushes_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr && !fv && !hold && !dn_q) |=> (pump == PUMP_UP));

    // R7
    coincident_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr && fv && !up_q && !dn_q) |=> (pump == PUMP_Z));

    // R10
    hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (pump == PUMP_Z));
endmodule

// File: rtl/lpb_status_sel.sv
// Status pin source: power-down state in normal use, divided waveform in test.
// Assumes: both sources are already in the clk domain.
module lpb_status_sel (
    input  logic test_sel,
    input  logic pwr_down,
    input  logic div_wave,
    output logic status
);
    // Pick the pin source.
    always_comb status = test_sel ? div_wave : pwr_down;
endmodule

// File: rtl/loop_phase_backend.sv
// One synthesizer loop back end: feedback divider, phase-frequency detector,
// lock flag and status pin. Assumes synchronous active-low reset.
module loop_phase_backend
    import lpb_pkg::*;
#(
    parameter int W       = 16,
    parameter int MIN_DIV = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vco_tick,
    input  logic         ref_strobe,
    input  logic [W-1:0] div_ratio,
    input  logic         pwr_down,
    input  logic         test_sel,
    output logic         err_up,
    output logic         err_dn,
    output logic         unlocked,
    output logic         status
);
    logic  fv_strobe;
    logic  div_wave;
    pump_e pump;

    lpb_fb_divider #(.W(W), .MIN_DIV(MIN_DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (pwr_down),
        .tick      (vco_tick),
        .ratio     (div_ratio),
        .fv_strobe (fv_strobe),
        .div_wave  (div_wave)
    );

    lpb_pfd u_pfd (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (pwr_down),
        .fr    (ref_strobe),
        .fv    (fv_strobe),
        .pump  (pump)
    );

    lpb_status_sel u_stat (
        .test_sel (test_sel),
        .pwr_down (pwr_down),
        .div_wave (div_wave),
        .status   (status)
    );

    // Pin drive enables and lock flag from the pump state.
    always_comb begin
        err_up   = (pump == PUMP_UP);
        err_dn   = (pump == PUMP_DN);
        unlocked = (pump != PUMP_Z);
    end
endmodule

// File: tb/tb_loop_phase_backend.sv
// Directed sweeps over divide ratios and strobe alignments with
// expected values computed from position arithmetic.
module tb_loop_phase_backend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vco_tick = 1'b0;
    logic        ref_strobe = 1'b0;
    logic [15:0] div_ratio = 16'd20;
    logic        pwr_down = 1'b0;
    logic        test_sel = 1'b0;
    logic        err_up, err_dn, unlocked, status;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    loop_phase_backend dut (
        .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_strobe(ref_strobe),
        .div_ratio(div_ratio), .pwr_down(pwr_down), .test_sel(test_sel),
        .err_up(err_up), .err_dn(err_dn), .unlocked(unlocked), .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one edge and settle half a period before sampling.
    task automatic step();
        @(posedge clk);
        #5;
    endtask

    // Pin-level invariants checked on every sample.
    task automatic pin_rules();
        chk("R8 both enables", int'(err_up && err_dn), 0);
        chk("R9 lock flag", int'(unlocked), int'(err_up || err_dn));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; vco_tick = 1'b0; ref_strobe = 1'b0; pwr_down = 1'b0;
        repeat (3) step();
        chk("reset err_up", int'(err_up), 0);
        chk("reset err_dn", int'(err_dn), 0);
        chk("reset unlocked", int'(unlocked), 0);
        rst_n = 1'b1;
    endtask

    // mode 1: no reference, 2: coincident, 3: reference leads, 4: divided leads
    function automatic bit fr_at(input int mode, input int e, input int n);
        case (mode)
            2: return (e > 1) && (e % n == 1);
            3: return (e % n == n - 2);
            4: return (e > n) && (e % n == 4);
            default: return 1'b0;
        endcase
    endfunction

    task automatic run(input int ratio, input int n, input int mode, input bit tst,
                       input int cycles);
        do_reset();
        div_ratio = 16'(ratio);
        test_sel  = tst;
        vco_tick  = 1'b1;
        ref_strobe = fr_at(mode, 1, n);
        for (int j = 1; j <= cycles; j++) begin
            int ph = j % n;
            int exp_dn = 0;
            int exp_up = 0;
            step();
            if (mode == 1) exp_dn = int'(j >= n + 1);
            if (mode == 4) exp_dn = int'(j >= n + 1 && ph >= 1 && ph <= 3);
            if (mode == 3) exp_up = int'(j >= n - 2 && (ph >= n - 2 || ph == 0));
            if (tst) chk("R3 divided wave", int'(status), int'(ph >= n / 2));
            else     chk("R4 status shows power state", int'(status), 0);
            if (mode == 1) chk("R1 R2 divided edge", int'(err_dn), exp_dn);
            if (mode == 2) chk("R7 coincident stays floating", int'(unlocked), 0);
            if (mode == 4) chk("R5 lead drives low", int'(err_dn), exp_dn);
            chk("R6 lag drives high", int'(err_up), exp_up);
            pin_rules();
            ref_strobe = fr_at(mode, j + 1, n);
        end
        vco_tick = 1'b0;
        ref_strobe = 1'b0;
    endtask

    initial begin
        #(20ns * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #5;
        // R1 R2 R3: ratio sweep with the divided wave on the status pin
        run(16, 16, 1, 1'b1, 60);
        run(17, 17, 1, 1'b1, 60);
        run(20, 20, 1, 1'b1, 70);
        run(5, 16, 1, 1'b1, 50);
        run(0, 16, 1, 1'b1, 50);
        run(20, 20, 1, 1'b0, 45);
        // R7 R5 R6 alignments
        run(20, 20, 2, 1'b1, 100);
        run(17, 17, 2, 1'b1, 80);
        run(20, 20, 3, 1'b1, 100);
        run(20, 20, 4, 1'b1, 100);

        // R10: power-down clears a pending lag and freezes everything
        do_reset();
        div_ratio = 16'd16; test_sel = 1'b0; vco_tick = 1'b1;
        for (int j = 1; j <= 5; j++) begin
            ref_strobe = (j == 3);
            step();
        end
        chk("R6 pending lag", int'(err_up), 1);
        ref_strobe = 1'b0;
        pwr_down = 1'b1;
        for (int j = 1; j <= 12; j++) begin
            ref_strobe = (j % 3 == 0);
            step();
            chk("R10 power-down float up", int'(err_up), 0);
            chk("R10 power-down float dn", int'(err_dn), 0);
            chk("R4 status reads power-down", int'(status), 1);
            pin_rules();
        end
        test_sel = 1'b1;
        ref_strobe = 1'b0;
        step();
        chk("R10 divider frozen at zero", int'(status), 0);
        pwr_down = 1'b0;
        for (int k = 1; k <= 17; k++) begin
            step();
            chk("R10 R3 restart wave", int'(status), int'((k % 16) >= 8));
            chk("R10 full count after release", int'(err_dn), int'(k >= 17));
            pin_rules();
        end
        vco_tick = 1'b0;

        // R1 upper bound: ratio 65535
        do_reset();
        div_ratio = 16'd65535; test_sel = 1'b1; vco_tick = 1'b1;
        for (int j = 1; j <= 65537; j++) begin
            step();
            if (j == 32766 || j == 32767 || j == 65534 || j == 65535)
                chk("R3 wide ratio wave", int'(status), int'((j % 65535) >= 32767));
            if (j >= 65534)
                chk("R1 wide ratio edge", int'(err_dn), int'(j >= 65536));
        end
        vco_tick = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule